// File: doc/BRIEF.md
# Four-Mode Register with In-Place Invert

A four-bit storage register whose next value is chosen each rising clock edge by a two-bit operation code. Every stored bit has a four-way selector in front of its flip-flop; the code picks whether the bit keeps its value, flips, goes to zero, or takes the matching bit of the data input. Clearing is ordinary clocked behaviour chosen through the code, not a separate wire.

A synchronous active-high reset puts the register at zero, independent of the clear operation. The block is used as a small control or scratch register where a whole-word invert in a single cycle is handy.

Top module: `opreg_top`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes 0 after that edge, whatever `op` and `d` are.
- R2: Op code 2'b00 (hold) leaves `q` unchanged across the edge; `d` has no effect.
- R3: Op code 2'b01 (invert) sets each bit of `q` to the inverse of its value before the edge; `d` has no effect.
- R4: Op code 2'b10 (clear) sets `q` to 4'b0000 at the edge; `d` has no effect.
- R5: Op code 2'b11 (load) sets `q` equal to `d` as sampled at the edge.
- R6: Two invert edges in a row bring `q` back to the value it had before the first one.
- R7: `op` is sampled only at the rising edge; changing it between edges does not change `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| op | input | 2 | Operation code: 00 hold, 01 invert, 10 clear, 11 load |
| d | input | 4 | Parallel data for the load operation |
| q | output | 4 | Stored value |

## Verification
The least direct case to reach is an invert followed by hold or clear from a value that is neither all zeros nor all ones, because only a load can set such a value. The stimulus therefore loads every one of the sixteen values, then runs invert, a second invert, hold and clear from each, while driving junk on `d` in the non-load operations. A mid-cycle change of `op` checks that nothing moves between edges.

// File: rtl/opreg_pkg.sv
package opreg_pkg;
    localparam int WIDTH = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_INV   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

    typedef logic [WIDTH-1:0] word_t;

    function automatic logic sel4(input op_e o, input logic cur, input logic din);
        case (o)
            OP_HOLD:  return cur;
            OP_INV:   return ~cur;
            OP_CLEAR: return 1'b0;
            default:  return din;
        endcase
    endfunction
endpackage

// File: rtl/opreg_bit.sv
module opreg_bit
    import opreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic din,
    output logic qb
);
    logic nxt;

    always_comb nxt = sel4(op, qb, din);

    always_ff @(posedge clk) begin
        if (rst) qb <= 1'b0;
        else     qb <= nxt;
    end

    assert_inv_bit_R3: assert property (@(posedge clk) disable iff (rst)
        op == OP_INV |=> qb != $past(qb));
endmodule

// File: rtl/opreg_top.sv
module opreg_top
    import opreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    op_e op_dec;

    always_comb op_dec = op_e'(op);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        opreg_bit u_bit (
            .clk (clk),
            .rst (rst),
            .op  (op_dec),
            .din (d[i]),
            .qb  (q[i])
        );
    end

    logic past_ok;
    always_ff @(posedge clk) past_ok <= 1'b1;

    assert_reset_R1: assert property (@(posedge clk)
        past_ok && $past(rst) |-> q == '0);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        op == 2'b00 |=> $stable(q));
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        op == 2'b10 |=> q == '0);
    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        op == 2'b11 |=> q == $past(d));
    assert_double_inv_R6: assert property (@(posedge clk) disable iff (rst)
        op == 2'b01 ##1 op == 2'b01 |=> q == $past(q, 2));
endmodule

// File: tb/opreg_top_test.sv
module opreg_top_test;
    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] op  = 0;
    logic [3:0] d   = 0;
    logic [3:0] q;
    int tests = 0, fails = 0;
    int model = 0;

    always #4 clk = ~clk;

    opreg_top uut (.clk(clk), .rst(rst), .op(op), .d(d), .q(q));

    task automatic chk(input string req, input int exp);
        tests++;
        if (q !== 4'(exp)) begin
            fails++;
            $display("FAIL %s q=%0h expected=%0h", req, q, exp);
        end
    endtask

    // reference model advanced behaviourally at every edge
    task automatic step(input int o, input int dv, input string req);
        op = 2'(o);
        d  = 4'(dv);
        @(posedge clk);
        if (rst) model = 0;
        else case (o)
            0: model = model;
            1: model = 15 - model;
            2: model = 0;
            default: model = dv;
        endcase
        #1;
        chk(req, model);
        #2;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog q=%0h expected=done", q);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1;
        step(3, 4'hF, "R1");
        step(1, 4'hA, "R1");
        rst = 0;
        for (int v = 0; v < 16; v++) begin
            step(3, v, "R5");
            step(0, 15 - v, "R2");
            step(1, 15 - v, "R3");
            step(1, v ^ 5, "R6");
            if (q !== 4'(v)) begin fails++; $display("FAIL R6 q=%0h expected=%0h", q, v); end
            tests++;
            step(1, v, "R3");
            step(0, 0, "R2");
            step(2, 4'hF, "R4");
            step(1, 3, "R3");
        end
        // R7: op toggles between edges, value only follows code at the edge
        step(3, 4'h6, "R5");
        op = 2'b10; #1; op = 2'b01; #1; chk("R7", 6);
        op = 2'b00; #1;
        @(posedge clk); #1; chk("R7", 6);
        // R1: reset overrides load
        rst = 1;
        step(3, 4'h9, "R1");
        rst = 0;
        step(3, 4'h9, "R5");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule